// File: doc/BRIEF.md
# Transform Core Memory Controller

This controller moves data between a shared SRAM and a block-transform engine. The host loads four configuration words and then pulses a start strobe. The controller asks an external arbiter for the SRAM. It then processes one 8x8 block at a time. For each block it reads 64 texture words and then 64 shape (alpha) words, and forwards them in that order to the transform engine over a valid/ready stream.

The engine sends its coefficients back over a second stream. Each block ends with a word that carries a last flag. The controller stores these words in a local buffer and writes them back to SRAM. Before moving on to the next block, it writes back only as many words as the engine actually produced. A block with a small shape therefore costs fewer SRAM cycles.

After the final block of the final frame, the request to the arbiter is dropped in the cycle right after the last write. A one-cycle done pulse marks this. If the grant falls while a transfer is in progress, the controller pauses its SRAM traffic and continues later without losing any data.

Top module: `xform_mem_ctrl`

## Requirements
- R1: After a synchronous active-low reset, arb_req, sram_en, core_in_valid, core_out_ready and done are all 0.
- R2: Configuration word layout, by select value:
  - Select 0 holds the width in bits 15:0 and the height in bits 31:16.
  - Select 1 holds the frame count in bits 15:0.
  - Select 2 holds the texture base in bits 15:0 and the shape base in bits 31:16.
  - Select 3 holds the output base in bits 15:0.
  - All four values are captured when a job starts, so later register writes do not affect the running job.
- R3: A start pulse in idle with nonzero work raises arb_req on the next cycle. No SRAM access happens before the grant. A start pulse during a job is ignored.
- R4: For block b, the read addresses are texture base + 64b + i, followed by shape base + 64b + i, for i from 0 to 63. Read data returns one cycle after a read enable. The words reach the engine in read order, with core_in_alpha set on the shape words and core_in_last set on word 128.
- R5: While core_in_valid is 1 and core_in_ready is 0, the controller holds core_in_valid and core_in_data unchanged.
- R6: Coefficient word j of block b is written to output base + 64b + j. Exactly the words up to and including the one flagged core_out_last are written, in order.
- R7: Blocks per frame equal floor(width/8) times floor(height/8). A job runs that count multiplied by the frame count. Addresses wrap modulo 2^16.
- R8: arb_req goes low in the cycle after the final write of a job. done is 1 in that same cycle only.
- R9: A start with zero frames, or with zero blocks per frame, pulses done on the next cycle and never raises arb_req.
- R10: sram_en is asserted only while both arb_req and arb_gnt are 1. A withdrawn grant stalls the transfer without dropping or repeating any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | One-cycle job start strobe |
| arb_req | output | 1 | SRAM request to arbiter |
| arb_gnt | input | 1 | SRAM grant from arbiter |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write (1) or read (0) |
| sram_addr | output | 16 | SRAM word address |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data, one cycle after a read |
| core_in_valid | output | 1 | Word to engine valid |
| core_in_ready | input | 1 | Engine accepts word |
| core_in_data | output | 16 | Texture or shape word |
| core_in_alpha | output | 1 | Word is a shape word |
| core_in_last | output | 1 | Final input word of a block |
| core_out_valid | input | 1 | Coefficient valid |
| core_out_ready | output | 1 | Controller accepts coefficient |
| core_out_data | input | 16 | Coefficient word |
| core_out_last | input | 1 | Final coefficient of a block |
| done | output | 1 | One-cycle job completion pulse |

## Verification
The assertions rely on the following engine behaviour:
- The engine emits at most 64 coefficient words per block.
- It flags exactly one of those words as last.
- It returns a block's results only after that block's inputs have been sent.

They also assume the SRAM answers every read on the following cycle. The bench's engine model follows these rules: each block gets a drawn result count between 1 and 64, the last flag is placed on the final word, and emission begins only once all 128 inputs of the block have been accepted. Grant, ready and valid gaps are drawn at random, so the stall paths run without breaking any of these assumptions.

// File: rtl/xmc_pkg.sv
// Shared types and register selects for the transform memory controller.
package xmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_t;

    localparam logic [1:0] SEL_DIMS   = 2'd0;
    localparam logic [1:0] SEL_FRAMES = 2'd1;
    localparam logic [1:0] SEL_RBASE  = 2'd2;
    localparam logic [1:0] SEL_WBASE  = 2'd3;
endpackage

// File: rtl/xmc_cfg_regs.sv
// Host configuration word file.
// Four words, selected by cfg_sel, each split into two half-words.
// Assumes DIM_W and ADDR_W each fit in half of CFG_W.
module xmc_cfg_regs import xmc_pkg::*; #(
    parameter int CFG_W  = 32,
    parameter int DIM_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [DIM_W-1:0]  width,
    output logic [DIM_W-1:0]  height,
    output logic [DIM_W-1:0]  frames,
    output logic [ADDR_W-1:0] tex_base,
    output logic [ADDR_W-1:0] shp_base,
    output logic [ADDR_W-1:0] out_base
);
    localparam int HALF = CFG_W / 2;

    // Capture host writes into the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width    <= '0;
            height   <= '0;
            frames   <= '0;
            tex_base <= '0;
            shp_base <= '0;
            out_base <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_DIMS: begin
                    width  <= cfg_wdata[DIM_W-1:0];
                    height <= cfg_wdata[HALF+DIM_W-1:HALF];
                end
                SEL_FRAMES: frames <= cfg_wdata[DIM_W-1:0];
                SEL_RBASE: begin
                    tex_base <= cfg_wdata[ADDR_W-1:0];
                    shp_base <= cfg_wdata[HALF+ADDR_W-1:HALF];
                end
                default: out_base <= cfg_wdata[ADDR_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/xmc_rd_path.sv
// Read side of one block.
// Issues 2*BLK_WORDS SRAM reads: the texture words first, then the shape words.
// Each returned word goes through a two-entry holding queue to the engine.
// A read is issued only when the queue plus the word in flight leave a slot free.
// Assumes read data returns exactly one cycle after the read enable.
module xmc_rd_path #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int BLK_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              blk_clear,
    input  logic              gnt,
    input  logic [ADDR_W-1:0] tex_addr,
    input  logic [ADDR_W-1:0] shp_addr,
    input  logic [DATA_W-1:0] rdata,
    input  logic              core_ready,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              core_valid,
    output logic [DATA_W-1:0] core_data,
    output logic              core_alpha,
    output logic              core_last,
    output logic              rd_done
);
    localparam int IDX_W = $clog2(BLK_WORDS);
    localparam int CNT_W = IDX_W + 2;
    localparam int TOTAL = 2 * BLK_WORDS;

    logic [CNT_W-1:0]  issue_cnt;
    logic              inflight, infl_alpha, infl_last;
    logic [DATA_W-1:0] hold_data  [2];
    logic              hold_alpha [2];
    logic              hold_last  [2];
    logic              hold_wp, hold_rp;
    logic [1:0]        hold_occ;
    logic              pop, issue_left, alpha_sel;
    logic [2:0]        used;

    // Issue decision and address selection for the next read.
    always_comb begin
        core_valid = (hold_occ != 2'd0);
        pop        = core_valid && core_ready;
        used       = {1'b0, hold_occ} + {2'b0, inflight} - {2'b0, pop};
        issue_left = (issue_cnt < CNT_W'(TOTAL));
        alpha_sel  = (issue_cnt >= CNT_W'(BLK_WORDS));
        rd_en      = run && gnt && issue_left && (used < 3'd2);
        rd_addr    = (alpha_sel ? shp_addr : tex_addr) + ADDR_W'(issue_cnt[IDX_W-1:0]);
        rd_done    = !issue_left && (hold_occ == 2'd0) && !inflight;
        core_data  = hold_data[hold_rp];
        core_alpha = hold_alpha[hold_rp];
        core_last  = hold_last[hold_rp];
    end

    // Count reads issued in the current block.
    always_ff @(posedge clk) begin
        if (!rst_n || blk_clear) issue_cnt <= '0;
        else if (rd_en)          issue_cnt <= issue_cnt + 1'b1;
    end

    // Track the single read in flight and its tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight   <= 1'b0;
            infl_alpha <= 1'b0;
            infl_last  <= 1'b0;
        end else begin
            inflight   <= rd_en;
            infl_alpha <= alpha_sel;
            infl_last  <= (issue_cnt == CNT_W'(TOTAL - 1));
        end
    end

    // Holding queue pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_wp  <= 1'b0;
            hold_rp  <= 1'b0;
            hold_occ <= 2'd0;
        end else begin
            if (inflight) hold_wp <= ~hold_wp;
            if (pop)      hold_rp <= ~hold_rp;
            hold_occ <= hold_occ + {1'b0, inflight} - {1'b0, pop};
        end
    end

    // Holding queue storage, written as read data returns.
    always_ff @(posedge clk) begin
        if (inflight) begin
            hold_data[hold_wp]  <= rdata;
            hold_alpha[hold_wp] <= infl_alpha;
            hold_last[hold_wp]  <= infl_last;
        end
    end

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid && !core_ready |=> core_valid && $stable(core_data) && $stable(core_alpha));
    a_r10_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, hold_occ} + {2'b0, inflight}) <= 3'd2);
endmodule

// File: rtl/xmc_wr_buf.sv
// Coefficient buffer and write-back for one block.
// Accepts engine results at any time while a job runs.
// Drains them to SRAM only in the write phase and only while granted.
// Reports when the word flagged last has been written.
// Assumes at most DEPTH words per block, exactly one of them flagged last.
module xmc_wr_buf #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              drain,
    input  logic              gnt,
    input  logic              blk_clear,
    input  logic [ADDR_W-1:0] base,
    input  logic              core_valid,
    input  logic [DATA_W-1:0] core_data,
    input  logic              core_last,
    output logic              core_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              blk_done
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp, wr_idx;
    logic [PTR_W:0]    count;
    logic              last_seen, push;

    // Handshake, drain and block-completion decisions.
    always_comb begin
        core_ready = accept && (count < (PTR_W+1)'(DEPTH));
        push       = core_valid && core_ready;
        wr_en      = drain && gnt && (count != '0);
        wr_addr    = base + ADDR_W'(wr_idx);
        wr_data    = mem[rp];
        blk_done   = drain && last_seen &&
                     ((count == '0) || ((count == (PTR_W+1)'(1)) && wr_en && !push));
    end

    // Buffer storage written on each accepted result.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= core_data;
    end

    // Pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push)  wp <= wp + 1'b1;
            if (wr_en) rp <= rp + 1'b1;
            count <= count + {{PTR_W{1'b0}}, push} - {{PTR_W{1'b0}}, wr_en};
        end
    end

    // Output word index and last-word tracking within a block.
    always_ff @(posedge clk) begin
        if (!rst_n || blk_clear) begin
            wr_idx    <= '0;
            last_seen <= 1'b0;
        end else begin
            if (wr_en)             wr_idx    <= wr_idx + 1'b1;
            if (push && core_last) last_seen <= 1'b1;
        end
    end

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (PTR_W+1)'(DEPTH));
    a_r6_write_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(count != '0) || $past(push));
endmodule

// File: rtl/xform_mem_ctrl.sv
// Transform memory controller top.
// Sequences a job over frames and blocks: read phase, then write phase, per block.
// Holds the SRAM request for the whole job and drops it right after the last write.
// Assumes the arbiter grant may drop at any cycle and the SRAM read latency is one cycle.
module xform_mem_ctrl import xmc_pkg::*; #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int DIM_W   = 16,
    parameter int BLK_DIM = 8,
    parameter int CFG_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              start,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic              sram_en,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              core_in_valid,
    input  logic              core_in_ready,
    output logic [DATA_W-1:0] core_in_data,
    output logic              core_in_alpha,
    output logic              core_in_last,
    input  logic              core_out_valid,
    output logic              core_out_ready,
    input  logic [DATA_W-1:0] core_out_data,
    input  logic              core_out_last,
    output logic              done
);
    localparam int BLK_WORDS = BLK_DIM * BLK_DIM;
    localparam int BLK_SHIFT = $clog2(BLK_DIM);
    localparam int BPF_W     = 2 * DIM_W;

    logic [DIM_W-1:0]  cfg_width, cfg_height, cfg_frames;
    logic [ADDR_W-1:0] cfg_tex, cfg_shp, cfg_out;
    seq_state_t        state;
    logic [BPF_W-1:0]  bpf_now, bpf_q, blk_in_frame;
    logic [DIM_W-1:0]  frames_q, frame_idx;
    logic [ADDR_W-1:0] tex_q, shp_q, out_q, blk_off;
    logic              done_q, no_work, launch, last_blk, advance, finish, blk_clear;
    logic              rd_en, rd_done, wr_en, wr_blk_done;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] wr_data;

    xmc_cfg_regs #(.CFG_W(CFG_W), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .width(cfg_width), .height(cfg_height), .frames(cfg_frames),
        .tex_base(cfg_tex), .shp_base(cfg_shp), .out_base(cfg_out)
    );

    // Job sizing and sequencing decisions.
    always_comb begin
        bpf_now   = BPF_W'(cfg_width >> BLK_SHIFT) * BPF_W'(cfg_height >> BLK_SHIFT);
        no_work   = (bpf_now == '0) || (cfg_frames == '0);
        launch    = (state == ST_IDLE) && start && !no_work;
        last_blk  = (frame_idx == frames_q - DIM_W'(1)) && (blk_in_frame == bpf_q - BPF_W'(1));
        advance   = (state == ST_WRITE) && wr_blk_done && !last_blk;
        finish    = (state == ST_WRITE) && wr_blk_done && last_blk;
        blk_clear = launch || advance;
        arb_req   = (state != ST_IDLE);
        done      = done_q;
    end

    // Phase sequencer with frame and block counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            done_q       <= 1'b0;
            bpf_q        <= '0;
            blk_in_frame <= '0;
            frames_q     <= '0;
            frame_idx    <= '0;
            tex_q        <= '0;
            shp_q        <= '0;
            out_q        <= '0;
            blk_off      <= '0;
        end else begin
            done_q <= ((state == ST_IDLE) && start && no_work) || finish;
            case (state)
                ST_IDLE: if (start) begin
                    bpf_q        <= bpf_now;
                    frames_q     <= cfg_frames;
                    tex_q        <= cfg_tex;
                    shp_q        <= cfg_shp;
                    out_q        <= cfg_out;
                    blk_off      <= '0;
                    blk_in_frame <= '0;
                    frame_idx    <= '0;
                    if (!no_work) state <= ST_READ;
                end
                ST_READ: if (rd_done) state <= ST_WRITE;
                ST_WRITE: begin
                    if (finish) begin
                        state <= ST_IDLE;
                    end else if (advance) begin
                        state   <= ST_READ;
                        blk_off <= blk_off + ADDR_W'(BLK_WORDS);
                        if (blk_in_frame == bpf_q - BPF_W'(1)) begin
                            blk_in_frame <= '0;
                            frame_idx    <= frame_idx + 1'b1;
                        end else begin
                            blk_in_frame <= blk_in_frame + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    xmc_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS)) u_rd (
        .clk(clk), .rst_n(rst_n), .run(state == ST_READ), .blk_clear(blk_clear),
        .gnt(arb_gnt), .tex_addr(tex_q + blk_off), .shp_addr(shp_q + blk_off),
        .rdata(sram_rdata), .core_ready(core_in_ready), .rd_en(rd_en), .rd_addr(rd_addr),
        .core_valid(core_in_valid), .core_data(core_in_data), .core_alpha(core_in_alpha),
        .core_last(core_in_last), .rd_done(rd_done)
    );

    xmc_wr_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(BLK_WORDS)) u_wr (
        .clk(clk), .rst_n(rst_n), .accept(state != ST_IDLE), .drain(state == ST_WRITE),
        .gnt(arb_gnt), .blk_clear(blk_clear), .base(out_q + blk_off),
        .core_valid(core_out_valid), .core_data(core_out_data), .core_last(core_out_last),
        .core_ready(core_out_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .blk_done(wr_blk_done)
    );

    // SRAM port sharing; the two phases never overlap.
    always_comb begin
        sram_en    = rd_en || wr_en;
        sram_we    = wr_en;
        sram_addr  = wr_en ? wr_addr : rd_addr;
        sram_wdata = wr_data;
    end

    a_r10_grant_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sram_en |-> arb_gnt && arb_req);
    a_r8_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !arb_req);
    a_r3_req_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> arb_req);
    a_r9_zero_job: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && start && no_work |=> done && !arb_req);
    a_r4_write_phase_only: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> state == ST_WRITE);
endmodule

// File: tb/xform_mem_ctrl_tb.sv
module xform_mem_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        arb_req, arb_gnt = 1'b0;
    logic        sram_en, sram_we;
    logic [15:0] sram_addr, sram_wdata;
    logic [15:0] sram_rdata = '0;
    logic        core_in_valid, core_in_ready = 1'b0, core_in_alpha, core_in_last;
    logic [15:0] core_in_data;
    logic        core_out_valid = 1'b0, core_out_ready, core_out_last = 1'b0;
    logic [15:0] core_out_data = '0;
    logic        done;

    int checks = 0, fails = 0, cyc = 0;
    bit job_on = 0, done_seen = 0, prev_done = 0, prev_stall = 0;
    logic [15:0] prev_data;
    int j_total, gmode, rmode;
    logic [15:0] j_tb, j_sb, j_ob;
    int rd_seen, in_seen, out_blk, out_j, wr_blk, wr_j, last_wr_cyc, done_cyc, job_bad;
    int n_of [64];

    always #10 clk = ~clk;

    xform_mem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .start(start), .arb_req(arb_req), .arb_gnt(arb_gnt), .sram_en(sram_en),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
        .sram_rdata(sram_rdata), .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
        .core_in_data(core_in_data), .core_in_alpha(core_in_alpha), .core_in_last(core_in_last),
        .core_out_valid(core_out_valid), .core_out_ready(core_out_ready),
        .core_out_data(core_out_data), .core_out_last(core_out_last), .done(done)
    );

    function automatic logic [15:0] f_mem(input logic [15:0] a);
        return (a * 16'd37) ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] g_coef(input int b, input int j);
        return 16'(b * 211 + j * 7 + 256);
    endfunction

    function automatic logic [15:0] exp_rd_addr(input int k);
        int b = k / 128;
        int i = k % 128;
        return ((i < 64) ? j_tb : j_sb) + 16'(b * 64) + 16'(i % 64);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            job_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // SRAM model: read data one cycle after the read enable
    always @(posedge clk) if (sram_en && !sram_we) sram_rdata <= f_mem(sram_addr);

    // Drive random inputs at the falling edge, then observe and check
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
        arb_gnt       = gmode != 0 ? (($urandom % 10) < 7) : 1'b1;
        core_in_ready = rmode != 0 ? (($urandom % 3) != 0) : 1'b1;
        if (job_on && out_blk < j_total && in_seen >= (out_blk + 1) * 128) begin
            core_out_valid = rmode != 0 ? (($urandom % 4) != 0) : 1'b1;
            core_out_data  = g_coef(out_blk, out_j);
            core_out_last  = (out_j == n_of[out_blk] - 1);
        end else begin
            core_out_valid = 1'b0;
            core_out_last  = 1'b0;
        end
        #1;
        if (sram_en) begin
            chk(arb_gnt && arb_req, "R10", "access without grant", arb_gnt, 1);
            if (!sram_we) begin
                chk(job_on && rd_seen < j_total * 128 && sram_addr == exp_rd_addr(rd_seen),
                    "R4", "read address", sram_addr, exp_rd_addr(rd_seen));
                rd_seen++;
            end else begin
                chk(job_on && wr_blk < j_total && sram_addr == j_ob + 16'(wr_blk * 64 + wr_j),
                    "R6", "write address", sram_addr, j_ob + 16'(wr_blk * 64 + wr_j));
                chk(sram_wdata == g_coef(wr_blk, wr_j), "R6", "write data", sram_wdata, g_coef(wr_blk, wr_j));
                last_wr_cyc = cyc;
                wr_j++;
                if (wr_blk < 64 && wr_j >= n_of[wr_blk]) begin
                    wr_blk++;
                    wr_j = 0;
                end
            end
        end
        if (prev_stall)
            chk(core_in_valid && core_in_data == prev_data, "R5", "held input word", core_in_data, prev_data);
        prev_stall = core_in_valid && !core_in_ready;
        prev_data  = core_in_data;
        if (core_in_valid && core_in_ready) begin
            chk(core_in_data == f_mem(exp_rd_addr(in_seen)) &&
                core_in_alpha == ((in_seen % 128) >= 64) &&
                core_in_last == ((in_seen % 128) == 127),
                "R4", "engine input word", core_in_data, f_mem(exp_rd_addr(in_seen)));
            in_seen++;
        end
        if (core_out_valid && core_out_ready) begin
            out_j++;
            if (out_j == n_of[out_blk]) begin
                out_blk++;
                out_j = 0;
            end
        end
        if (done) begin
            if (prev_done) chk(0, "R8", "done wider than one cycle", 2, 1);
            done_seen = 1;
            done_cyc  = cyc;
        end
        prev_done = done;
    end

    task automatic wr_cfg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_job(input int w, input int h, input int fr, input logic [15:0] tb,
                           input logic [15:0] sb, input logic [15:0] ob, input int gm,
                           input int rm, input bit disturb);
        int guard = 0;
        j_total = (w / 8) * (h / 8) * fr;
        j_tb = tb; j_sb = sb; j_ob = ob;
        rd_seen = 0; in_seen = 0; out_blk = 0; out_j = 0; wr_blk = 0; wr_j = 0; job_bad = 0;
        for (int b = 0; b < 64; b++) n_of[b] = 1 + ($urandom % 64);
        n_of[0] = 64;
        if (j_total > 1) n_of[j_total - 1] = 1;
        wr_cfg(2'd0, {16'(h), 16'(w)});
        wr_cfg(2'd1, {16'd0, 16'(fr)});
        wr_cfg(2'd2, {sb, tb});
        wr_cfg(2'd3, {16'd0, ob});
        gmode = gm; rmode = rm;
        done_seen = 0;
        job_on = 1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #2;
        if (j_total == 0) begin
            chk(done && !arb_req, "R9", "zero job done without request", done, 1);
            @(negedge clk); #2;
            chk(!done && !arb_req && rd_seen == 0, "R9", "zero job quiet", done, 0);
            job_on = 0;
            return;
        end
        chk(arb_req, "R3", "request after start", arb_req, 1);
        if (disturb) begin
            repeat (200) @(negedge clk);
            pulse_start();
            wr_cfg(2'd3, 32'h0000_7777);
            wr_cfg(2'd2, 32'h1111_2222);
        end
        while (!done_seen && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        #2;
        chk(done_seen, "R8", "done seen", done_seen, 1);
        chk(rd_seen == j_total * 128 && in_seen == j_total * 128, "R7", "words read for all blocks",
            rd_seen, j_total * 128);
        chk(wr_blk == j_total && wr_j == 0, "R6", "blocks written", wr_blk, j_total);
        chk(done_cyc == last_wr_cyc + 1, "R8", "release right after last write", done_cyc, last_wr_cyc + 1);
        if (disturb) chk(job_bad == 0, "R2", "job unaffected by late writes and start", job_bad, 0);
        if (disturb) chk(rd_seen == j_total * 128, "R3", "second start ignored", rd_seen, j_total * 128);
        @(negedge clk); #2;
        chk(!done && !arb_req && !sram_en, "R8", "idle after done", done, 0);
        job_on = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(!arb_req && !sram_en && !core_in_valid && !core_out_ready && !done, "R1", "reset state",
            {arb_req, sram_en, core_in_valid, core_out_ready, done}, 0);
        // zero frames, then zero blocks per frame (width below one block)
        run_job(16, 16, 0, 16'h0100, 16'h0200, 16'h0300, 0, 0, 0);
        run_job(7, 64, 2, 16'h0100, 16'h0200, 16'h0300, 0, 0, 0);
        // two blocks per frame, two frames, free-running grant and ready
        run_job(16, 8, 2, 16'h1000, 16'h2000, 16'h3000, 0, 0, 0);
        // truncated dims (2x1 blocks), three frames, address wrap, random stalls, disturbances
        run_job(20, 15, 3, 16'hFFE0, 16'h4000, 16'h8000, 1, 1, 1);
        // single full-size block under random stalls
        run_job(8, 8, 1, 16'h0040, 16'h0C00, 16'hFFF0, 1, 1, 0);
        summary();
    end
endmodule